// File: doc/BRIEF.md
# Four-Stage Pipeline Hazard Controller

This block steps instructions through a four-stage pipeline: Fetch, Decode, Operate and Write. Instructions arrive on a fetch port with a valid/ready handshake. Each one carries a tag, a destination register, two source registers, a write-enable flag, a branch flag, a conditional flag and a branch target. Three buffer registers hold the instructions in Decode, Operate and Write. All occupied stages advance together on the same clock edge.

The block handles two kinds of hazard. For data hazards, a per-register pending-write counter makes an instruction wait in Decode until every older writer of one of its sources has finished Write. No forwarding is done. While an instruction waits, idle slots go down the pipeline. For branch hazards, an unconditional branch releases its target fetch in the cycle after it leaves Decode. A conditional branch holds Fetch while it sits in Operate, where the taken/not-taken outcome input is valid. On a taken branch, the sequentially fetched instruction is thrown away.

The block reports stage occupancy every cycle and gives a retire pulse with the tag of each instruction that completes Write. It has no datapath arithmetic.

Top module: `pipe4_hazard_ctrl`

## Requirements
- R1: After reset, stage_busy is 0, retire_valid is 0, redirect_valid is 0 and fetch_ready is 1.
- R2: With no hazards, an instruction accepted on the fetch port in cycle c shows retire_valid with its tag in cycle c+3. Back-to-back instructions retire one per cycle.
- R3: The bits of stage_busy are: bit 0 is a fetch transfer this cycle, bit 1 is Decode occupied, bit 2 is Operate occupied, bit 3 is Write occupied. In a full stream all four bits are 1.
- R4: Suppose an instruction reads a register that an older in-flight writer has not yet written. It waits in Decode until the cycle in which that writer is in Write, and enters Operate on the next cycle. While it waits, fetch_ready is 0 and Operate receives an empty slot. For a producer immediately ahead, this adds one cycle of latency. For a producer two ahead, it adds none.
- R5: Retire pulses come in fetch order, only for real instructions. Empty slots and discarded instructions never retire.
- R6: An unconditional branch (branch=1, cond=0) leaving Decode discards the instruction fetched in the same cycle. From the next cycle, redirect_valid is 1 with the branch target, and it holds until a fetch transfer occurs.
- R7: While a conditional branch (branch=1, cond=1) is in Operate, fetch_ready is 0 and Decode does not advance.
- R8: A taken conditional branch (op_taken=1 while it is in Operate) discards the instruction waiting in Decode. It raises redirect_valid with its target in the following cycle.
- R9: A not-taken conditional branch raises no redirect. The waiting instruction continues and retires, with latency 4.
- R10: A source with two older writers in flight stays blocked until the younger of the two reaches Write.
- R11: An instruction with wr=0 never blocks a later reader of its destination field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch port offers an instruction |
| fetch_ready | output | 1 | Pipeline accepts an instruction this cycle |
| fetch_tag | input | TAG_W | Instruction identifier |
| fetch_dst | input | REG_W | Destination register |
| fetch_src_a | input | REG_W | First source register |
| fetch_src_b | input | REG_W | Second source register |
| fetch_wr | input | 1 | Instruction writes its destination |
| fetch_branch | input | 1 | Instruction is a branch |
| fetch_cond | input | 1 | Branch is conditional |
| fetch_target | input | PC_W | Branch target address |
| op_taken | input | 1 | Outcome of the conditional branch in Operate |
| redirect_valid | output | 1 | New fetch address is released |
| redirect_target | output | PC_W | Address to fetch from |
| stage_busy | output | 4 | Per-stage occupancy, bit 0 Fetch to bit 3 Write |
| retire_valid | output | 1 | An instruction completes Write |
| retire_tag | output | TAG_W | Tag of the retiring instruction |

## Verification
The bench uses the default package values: 8-bit tags and targets, eight registers and 2-bit pending counters. Eight registers are enough to give each hazard scenario its own producer register, so no scenario inherits pending state from another. A 2-bit counter can hold the two overlapping writers of the double-writer case, so the counter depth itself is tested. Latencies are measured from the fetch cycle to the retire cycle. This lets each stall and discard show up as an exact cycle count.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  parameter int TAG_W = 8;
  parameter int REG_W = 3;
  parameter int PC_W  = 8;
  parameter int CNT_W = 2;
  localparam int NREG = 1 << REG_W;

  typedef struct packed {
    logic             vld;
    logic [TAG_W-1:0] tag;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src_a;
    logic [REG_W-1:0] src_b;
    logic             wr;
    logic             br;
    logic             cond;
    logic [PC_W-1:0]  tgt;
  } slot_t;

  // A source is blocked when either operand register still awaits a write.
  function automatic logic src_blocked(input logic [NREG-1:0] pend,
                                       input logic [REG_W-1:0] a,
                                       input logic [REG_W-1:0] b);
    return pend[a] | pend[b];
  endfunction

  // Pending-writer count after one cycle of issue and completion.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cnt,
                                                  input logic inc,
                                                  input logic dec);
    return cnt + CNT_W'(inc) - CNT_W'(dec);
  endfunction
endpackage

// File: rtl/pipe4_scoreboard.sv
module pipe4_scoreboard
  import pipe4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [REG_W-1:0] inc_reg,
  input  logic             dec_en,
  input  logic [REG_W-1:0] dec_reg,
  output logic [NREG-1:0]  pending
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CNT_W-1:0] cnt;
    logic inc_hit, dec_hit;
    assign inc_hit = inc_en && (inc_reg == REG_W'(r));
    assign dec_hit = dec_en && (dec_reg == REG_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= next_count(cnt, inc_hit, dec_hit);
    end
    // A writer completing this cycle no longer blocks its readers.
    assign pending[r] = (cnt != CNT_W'(dec_hit));
  end
endmodule

// File: rtl/pipe4_redirect.sv
module pipe4_redirect
  import pipe4_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [PC_W-1:0] set_tgt,
  input  logic            fetch_fire,
  output logic            redirect_valid,
  output logic [PC_W-1:0] redirect_target
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_valid  <= 1'b0;
      redirect_target <= '0;
    end else if (set_en) begin
      redirect_valid  <= 1'b1;
      redirect_target <= set_tgt;
    end else if (fetch_fire) begin
      redirect_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/pipe4_hazard_ctrl.sv
module pipe4_hazard_ctrl
  import pipe4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_valid,
  output logic             fetch_ready,
  input  logic [TAG_W-1:0] fetch_tag,
  input  logic [REG_W-1:0] fetch_dst,
  input  logic [REG_W-1:0] fetch_src_a,
  input  logic [REG_W-1:0] fetch_src_b,
  input  logic             fetch_wr,
  input  logic             fetch_branch,
  input  logic             fetch_cond,
  input  logic [PC_W-1:0]  fetch_target,
  input  logic             op_taken,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_target,
  output logic [3:0]       stage_busy,
  output logic             retire_valid,
  output logic [TAG_W-1:0] retire_tag
);
  slot_t fd_q, dx_q, ow_q, fetched;
  logic [NREG-1:0] pend;

  // Named internal events, observed by the bound checker.
  logic cond_hold, taken_now, raw_stall, dec_go, fetch_fire, uncond_go;
  logic redir_set;
  logic [PC_W-1:0] redir_tgt;

  assign fetched = '{vld: 1'b1, tag: fetch_tag, dst: fetch_dst,
                     src_a: fetch_src_a, src_b: fetch_src_b, wr: fetch_wr,
                     br: fetch_branch, cond: fetch_cond, tgt: fetch_target};

  assign cond_hold   = dx_q.vld && dx_q.br && dx_q.cond;
  assign taken_now   = cond_hold && op_taken;
  assign raw_stall   = fd_q.vld && src_blocked(pend, fd_q.src_a, fd_q.src_b);
  assign dec_go      = fd_q.vld && !raw_stall && !cond_hold;
  assign fetch_ready = (!fd_q.vld || dec_go) && !cond_hold;
  assign fetch_fire  = fetch_valid && fetch_ready;
  assign uncond_go   = dec_go && fd_q.br && !fd_q.cond;
  assign redir_set   = uncond_go || taken_now;
  assign redir_tgt   = taken_now ? dx_q.tgt : fd_q.tgt;

  // Fetch/Decode buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fd_q <= '0;
    end else if (fetch_fire) begin
      fd_q     <= fetched;
      fd_q.vld <= !uncond_go;        // sequential successor of a jump is dropped
    end else if (dec_go || taken_now) begin
      fd_q.vld <= 1'b0;              // moved on, or squashed by a taken branch
    end
  end

  // Decode/Operate and Operate/Write buffers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dx_q <= '0;
      ow_q <= '0;
    end else begin
      dx_q     <= fd_q;
      dx_q.vld <= dec_go;            // bubble when Decode holds
      ow_q     <= dx_q;
    end
  end

  pipe4_scoreboard u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (dec_go && fd_q.wr),
    .inc_reg (fd_q.dst),
    .dec_en  (ow_q.vld && ow_q.wr),
    .dec_reg (ow_q.dst),
    .pending (pend)
  );

  pipe4_redirect u_redir (
    .clk             (clk),
    .rst_n           (rst_n),
    .set_en          (redir_set),
    .set_tgt         (redir_tgt),
    .fetch_fire      (fetch_fire),
    .redirect_valid  (redirect_valid),
    .redirect_target (redirect_target)
  );

  assign stage_busy   = {ow_q.vld, dx_q.vld, fd_q.vld, fetch_fire};
  assign retire_valid = ow_q.vld;
  assign retire_tag   = ow_q.tag;
endmodule

// File: rtl/pipe4_hazard_checker.sv
module pipe4_hazard_checker
  import pipe4_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_valid,
  input logic            fetch_ready,
  input logic [3:0]      stage_busy,
  input logic            retire_valid,
  input logic            redirect_valid,
  input logic [PC_W-1:0] redirect_target,
  input logic            raw_stall,
  input logic            cond_hold,
  input logic            taken_now
);
  logic xfer;
  assign xfer = fetch_valid && fetch_ready;

  assert_stall_blocks_fetch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    raw_stall |-> !fetch_ready);

  assert_stall_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
    raw_stall |=> !stage_busy[2]);

  assert_cond_holds_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cond_hold |-> !fetch_ready);

  assert_taken_redirects_R8: assert property (@(posedge clk) disable iff (!rst_n)
    taken_now |=> redirect_valid);

  assert_redirect_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !xfer) |=> (redirect_valid && $stable(redirect_target)));

  assert_retire_follows_operate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> $past(stage_busy[2]));
endmodule

bind pipe4_hazard_ctrl pipe4_hazard_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .fetch_valid     (fetch_valid),
  .fetch_ready     (fetch_ready),
  .stage_busy      (stage_busy),
  .retire_valid    (retire_valid),
  .redirect_valid  (redirect_valid),
  .redirect_target (redirect_target),
  .raw_stall       (raw_stall),
  .cond_hold       (cond_hold),
  .taken_now       (taken_now)
);

// File: tb/pipe4_hazard_ctrl_test.sv
`timescale 1ns/1ps
module pipe4_hazard_ctrl_test;
  import pipe4_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0;
  logic fetch_ready;
  logic [TAG_W-1:0] fetch_tag = '0;
  logic [REG_W-1:0] fetch_dst = '0, fetch_src_a = '0, fetch_src_b = '0;
  logic fetch_wr = 1'b0, fetch_branch = 1'b0, fetch_cond = 1'b0;
  logic [PC_W-1:0] fetch_target = '0;
  logic op_taken = 1'b0;
  logic redirect_valid;
  logic [PC_W-1:0] redirect_target;
  logic [3:0] stage_busy;
  logic retire_valid;
  logic [TAG_W-1:0] retire_tag;

  always #2 clk = ~clk;   // 250 MHz

  pipe4_hazard_ctrl uut (.*);

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchecks = 0, nerr = 0;
  bit finished = 1'b0;
  int q_tag[$], q_lat[$], q_fc[$];
  string q_req[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: offers one instruction, waits for acceptance, queues the expectation.
  task automatic issue(input int tag, input int dst, input int sa, input int sb,
                       input bit wr, input bit br, input bit cnd, input int tgt,
                       input int lat, input string req);
    fetch_tag = TAG_W'(tag); fetch_dst = REG_W'(dst);
    fetch_src_a = REG_W'(sa); fetch_src_b = REG_W'(sb);
    fetch_wr = wr; fetch_branch = br; fetch_cond = cnd;
    fetch_target = PC_W'(tgt); fetch_valid = 1'b1;
    while (!fetch_ready) @(negedge clk);
    if (lat >= 0) begin
      q_tag.push_back(tag); q_lat.push_back(lat);
      q_fc.push_back(cyc); q_req.push_back(req);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    fetch_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares each retirement against the queue head.
  always @(negedge clk) begin
    if (rst_n && retire_valid && !finished) begin
      if (q_tag.size() == 0) begin
        chk(1'b0, "R5", "unexpected retire tag", int'(retire_tag), -1);
      end else begin
        int et, el, ef; string er;
        et = q_tag.pop_front(); el = q_lat.pop_front();
        ef = q_fc.pop_front();  er = q_req.pop_front();
        chk(int'(retire_tag) == et, "R5", "retire order tag", int'(retire_tag), et);
        chk((cyc - ef) == el, er, "retire latency", cyc - ef, el);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchecks++; nerr++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(stage_busy == 4'b0000, "R1", "stage_busy", int'(stage_busy), 0);
    chk(!retire_valid, "R1", "retire_valid", int'(retire_valid), 0);
    chk(!redirect_valid, "R1", "redirect_valid", int'(redirect_valid), 0);
    chk(fetch_ready, "R1", "fetch_ready", int'(fetch_ready), 1);

    // R2 stream of independent writers, R3 full occupancy
    issue(1, 7, 0, 0, 1, 0, 0, 0, 3, "R2");
    issue(2, 7, 0, 0, 1, 0, 0, 0, 3, "R2");
    issue(3, 7, 0, 0, 1, 0, 0, 0, 3, "R2");
    chk(stage_busy == 4'b1111, "R3", "stage_busy full", int'(stage_busy), 15);
    issue(4, 7, 0, 0, 1, 0, 0, 0, 3, "R2");
    issue(5, 6, 0, 0, 1, 0, 0, 0, 3, "R2");
    issue(6, 5, 0, 0, 1, 0, 0, 0, 3, "R2");
    idle(8);

    // R4 adjacent read-after-write: one stall cycle, bubble in Operate
    issue(10, 1, 0, 0, 1, 0, 0, 0, 3, "R4");
    issue(11, 2, 1, 0, 1, 0, 0, 0, 4, "R4");
    fetch_valid = 1'b0;
    chk(!fetch_ready, "R4", "ready during stall", int'(fetch_ready), 0);
    @(negedge clk);
    chk(!stage_busy[2], "R4", "bubble in Operate", int'(stage_busy[2]), 0);
    chk(fetch_ready, "R4", "ready after stall", int'(fetch_ready), 1);
    issue(12, 0, 0, 0, 0, 0, 0, 0, 3, "R4");
    idle(8);

    // R4 producer two ahead: no stall
    issue(20, 2, 0, 0, 1, 0, 0, 0, 3, "R4");
    issue(21, 0, 0, 0, 0, 0, 0, 0, 3, "R4");
    issue(22, 0, 0, 2, 0, 0, 0, 0, 3, "R4");
    idle(8);

    // R10 two writers of the same register
    issue(30, 3, 0, 0, 1, 0, 0, 0, 3, "R10");
    issue(31, 3, 0, 0, 1, 0, 0, 0, 3, "R10");
    issue(32, 0, 3, 0, 0, 0, 0, 0, 4, "R10");
    idle(8);

    // R11 non-writer does not block
    issue(40, 4, 0, 0, 0, 0, 0, 0, 3, "R11");
    issue(41, 0, 4, 4, 0, 0, 0, 0, 3, "R11");
    idle(8);

    // R6 unconditional branch
    issue(50, 0, 0, 0, 0, 1, 0, 8'h40, 3, "R6");
    issue(51, 0, 0, 0, 0, 0, 0, 0, -1, "R6");
    chk(redirect_valid, "R6", "redirect_valid", int'(redirect_valid), 1);
    chk(redirect_target == 8'h40, "R6", "redirect_target", int'(redirect_target), 'h40);
    fetch_valid = 1'b0;
    @(negedge clk);
    chk(redirect_valid, "R6", "redirect held", int'(redirect_valid), 1);
    chk(redirect_target == 8'h40, "R6", "target held", int'(redirect_target), 'h40);
    issue(52, 0, 0, 0, 0, 0, 0, 0, 3, "R6");
    chk(!redirect_valid, "R6", "redirect cleared", int'(redirect_valid), 0);
    idle(8);

    // R7, R8 conditional branch taken
    op_taken = 1'b1;
    issue(60, 0, 0, 0, 0, 1, 1, 8'h80, 3, "R8");
    issue(61, 0, 0, 0, 0, 0, 0, 0, -1, "R8");
    fetch_valid = 1'b0;
    chk(!fetch_ready, "R7", "ready while cond in Operate", int'(fetch_ready), 0);
    chk(!redirect_valid, "R8", "no early redirect", int'(redirect_valid), 0);
    @(negedge clk);
    op_taken = 1'b0;
    chk(redirect_valid, "R8", "redirect_valid", int'(redirect_valid), 1);
    chk(redirect_target == 8'h80, "R8", "redirect_target", int'(redirect_target), 'h80);
    issue(62, 0, 0, 0, 0, 0, 0, 0, 3, "R8");
    idle(8);

    // R7, R9 conditional branch not taken
    issue(70, 0, 0, 0, 0, 1, 1, 8'h90, 3, "R9");
    issue(71, 0, 0, 0, 0, 0, 0, 0, 4, "R9");
    fetch_valid = 1'b0;
    chk(!fetch_ready, "R7", "ready while cond in Operate", int'(fetch_ready), 0);
    chk(stage_busy[1], "R7", "Decode held", int'(stage_busy[1]), 1);
    @(negedge clk);
    chk(!redirect_valid, "R9", "no redirect", int'(redirect_valid), 0);
    chk(fetch_ready, "R9", "fetch resumes", int'(fetch_ready), 1);
    issue(72, 0, 0, 0, 0, 0, 0, 0, 3, "R9");
    idle(10);

    chk(q_tag.size() == 0, "R5", "missing retirements", q_tag.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    $finish;
  end
endmodule